// File: doc/BRIEF.md
# Audio port control/status register file

This block is the software-facing register file of a serial audio port. A host reaches it over a simple 32-bit register bus with word stride. Through it the host turns the receiver, the transmitter and the bit clock on and off, programs a free-form mode word, moves single samples through a receive and a transmit holding register, and watches a status word. The serial shifters and the clock generator sit outside this block. They see only the enable levels, the mode word and the transmit sample, and they report events back on plain ports.

The receive datapath pulses a strobe with each new sample and its TDM channel number. If the previous sample was still unread, the block records a sticky overrun both globally and for that channel. The transmit datapath pulses a take request with a channel number. If the holding register is empty at that moment, the block records a sticky underrun both globally and for that channel. Sticky bits are cleared by writing ones to a clear alias and forced by writing ones to a set alias. Four status sources (receive ready, receive overrun, transmit ready, transmit underrun) pass through an interrupt mask to form one level interrupt.

The bus decodes address bits 5:2 as the word index and ignores bits 1:0. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are high. Read data is combinational and is zero unless `bus_sel` is high and `bus_wr` is low.

Top module: `aud_csr_top`

## Requirements
- R1: After `rst`, or after a write to the command word (byte 0x00) with bit 7 set, the enables, the mode word, the interrupt mask and all sticky bits are zero. Receive ready is 0, transmit ready is 1 (holding register empty), and the status word reads 0x20. A reset write ignores every other bit written with it, and the version word is unchanged.
- R2: Command bits come in pairs that act on the next cycle: bit 0/1 turns the receiver on/off, bit 2/3 the clock, and bit 4/5 the transmitter. If both bits of a pair are set in one write, that function ends up off. A pair written as zeros keeps its level.
- R3: The mode word at byte 0x04 is read/write, and its value drives `mode_cfg`.
- R4: The status word at byte 0x08 has this layout:
  - bit 0: receiver on; bit 1: receive ready; bit 2: receive overrun
  - bit 4: transmitter on; bit 5: transmit ready; bit 6: transmit underrun
  - bits 15:8: receive overrun per channel 0..7
  - bits 27:20: transmit underrun per channel 0..7
  - every other bit reads 0.
- R5: While the receiver is on, `rx_strobe` loads `rx_sample` into the receive holding register and sets receive ready. Reading byte 0x20 returns that sample and clears ready. A strobe that arrives while ready is set, with no read of 0x20 in the same cycle, also sets the overrun bit and the bit of `rx_chan`. A strobe while the receiver is off is ignored.
- R6: A write to byte 0x24 loads the transmit holding register, which drives `tx_sample`, and clears transmit ready. While the transmitter is on, `tx_take` empties the holding register (ready goes to 1). A take that finds the register empty sets the underrun bit and the bit of `tx_chan`. A take while the transmitter is off is ignored.
- R7: Writing ones to the clear alias at byte 0x0C clears the matching sticky bits (2, 6, 15:8, 27:20). An event in the same cycle wins over the clear, and no other status bit changes.
- R8: Writing ones to the set alias at byte 0x10 sets the matching sticky bits only. The enable and ready bits do not change.
- R9: A write to byte 0x14 sets mask bits and a write to byte 0x18 clears them. Only bits 1, 2, 5 and 6 exist. Byte 0x1C reads the mask, and writing to 0x1C has no effect.
- R10: `irq` is high exactly when a status bit at position 1, 2, 5 or 6 is set together with its mask bit. It follows the registers in the same cycle.
- R11: Reads of the write-only words (0x00, 0x0C, 0x10, 0x14, 0x18, 0x24) and of unmapped words return zero. Byte 0x28 returns the `VERSION` parameter and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address, bits 5:2 used |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| rx_strobe | input | 1 | Receive datapath has a new sample |
| rx_chan | input | 3 | TDM channel of that sample |
| rx_sample | input | 32 | Received sample |
| tx_take | input | 1 | Transmit datapath consumes the holding register |
| tx_chan | input | 3 | TDM channel of that request |
| tx_sample | output | 32 | Transmit holding register |
| rx_enable | output | 1 | Receiver on |
| tx_enable | output | 1 | Transmitter on |
| clk_enable | output | 1 | Bit clock generator on |
| mode_cfg | output | 32 | Mode word |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the same-cycle collisions:
- A strobe together with a holding-register read must not count as an overrun. A design that got this wrong would flag an overrun on every streamed read.
- A clear write together with a new overrun must keep the new event. A design that got this wrong would silently lose an error.
- A write of both bits of a command pair must leave the function off. A design that got this wrong would leave a stream running.

It also checks that events arriving while a function is off leave ready untouched. It checks that the set alias leaves the enable and ready bits alone, and that a reset command wipes everything even when other command bits ride along with it. A behavioural model compares every output each cycle, which exposes a wrong per-channel bit position or an interrupt driven from an unmasked source.

// File: rtl/aud_csr_pkg.sv
package aud_csr_pkg;

    localparam int unsigned DW     = 32;
    localparam int unsigned ADDR_W = 6;

    // word indices (byte address bits 5:2)
    localparam logic [3:0] W_CMD  = 4'd0;
    localparam logic [3:0] W_MODE = 4'd1;
    localparam logic [3:0] W_STAT = 4'd2;
    localparam logic [3:0] W_SCLR = 4'd3;
    localparam logic [3:0] W_SSET = 4'd4;
    localparam logic [3:0] W_IEN  = 4'd5;
    localparam logic [3:0] W_IDIS = 4'd6;
    localparam logic [3:0] W_IMSK = 4'd7;
    localparam logic [3:0] W_RHR  = 4'd8;
    localparam logic [3:0] W_THR  = 4'd9;
    localparam logic [3:0] W_VER  = 4'd10;

    // status bit positions
    localparam int unsigned B_RXEN  = 0;
    localparam int unsigned B_RXRDY = 1;
    localparam int unsigned B_RXOVR = 2;
    localparam int unsigned B_TXEN  = 4;
    localparam int unsigned B_TXRDY = 5;
    localparam int unsigned B_TXUR  = 6;
    localparam int unsigned B_RXCH  = 8;
    localparam int unsigned B_TXCH  = 20;

    // command reset bit
    localparam int unsigned B_SWRST = 7;

    // status sources that may raise the interrupt
    localparam logic [DW-1:0] IRQ_BITS = 32'h0000_0066;

    // controlled functions; enable bit = 2*f, disable bit = 2*f+1
    typedef enum logic [1:0] {
        FN_RX  = 2'd0,
        FN_CLK = 2'd1,
        FN_TX  = 2'd2
    } func_e;
    localparam int unsigned NFUNC = 3;

    typedef struct packed {
        logic cmd;
        logic mode;
        logic sclr;
        logic sset;
        logic ien;
        logic idis;
        logic thr_wr;
        logic rhr_rd;
    } csr_strb_t;

    function automatic csr_strb_t csr_decode(input logic sel, input logic wr,
                                             input logic [3:0] widx);
        csr_strb_t s;
        s        = '0;
        s.cmd    = sel && wr && (widx == W_CMD);
        s.mode   = sel && wr && (widx == W_MODE);
        s.sclr   = sel && wr && (widx == W_SCLR);
        s.sset   = sel && wr && (widx == W_SSET);
        s.ien    = sel && wr && (widx == W_IEN);
        s.idis   = sel && wr && (widx == W_IDIS);
        s.thr_wr = sel && wr && (widx == W_THR);
        s.rhr_rd = sel && !wr && (widx == W_RHR);
        return s;
    endfunction

    // sticky positions for a given channel count
    function automatic logic [DW-1:0] sticky_mask(input int unsigned nch);
        logic [DW-1:0] m;
        m          = '0;
        m[B_RXOVR] = 1'b1;
        m[B_TXUR]  = 1'b1;
        for (int unsigned i = 0; i < nch; i++) begin
            m[B_RXCH + i] = 1'b1;
            m[B_TXCH + i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/aud_csr_cmd.sv
module aud_csr_cmd
    import aud_csr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               swrst,
    input  logic               cmd_we,
    input  logic [2*NFUNC-1:0] cmd_bits,
    output logic [NFUNC-1:0]   en
);

    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
        always_ff @(posedge clk) begin
            if (rst || swrst) begin
                en[f] <= 1'b0;
            end else if (cmd_we) begin
                if (cmd_bits[2*f+1])
                    en[f] <= 1'b0;
                else if (cmd_bits[2*f])
                    en[f] <= 1'b1;
            end
        end

        AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (rst)
            (cmd_we && cmd_bits[2*f+1]) |=> !en[f]); // R2

        AST_ZERO_PAIR_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (cmd_we && !swrst && !cmd_bits[2*f] && !cmd_bits[2*f+1]) |=> $stable(en[f])); // R2
    end

endmodule

// File: rtl/aud_csr_status.sv
module aud_csr_status
    import aud_csr_pkg::*;
#(
    parameter int unsigned NCH  = 8,
    parameter int unsigned SW   = 32,
    localparam int unsigned CH_W = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            swrst,
    input  logic            rx_en,
    input  logic            tx_en,
    input  logic            sclr,
    input  logic            sset,
    input  logic            thr_wr,
    input  logic            rhr_rd,
    input  logic [DW-1:0]   wdata,
    input  logic            rx_strobe,
    input  logic [CH_W-1:0] rx_chan,
    input  logic [SW-1:0]   rx_sample,
    input  logic            tx_take,
    input  logic [CH_W-1:0] tx_chan,
    output logic [DW-1:0]   status,
    output logic [SW-1:0]   rx_hold,
    output logic [SW-1:0]   tx_hold
);

    localparam logic [DW-1:0] STK = sticky_mask(NCH);

    logic          rx_rdy;
    logic          tx_empty;
    logic [DW-1:0] stk;
    logic          rx_acc, tx_acc, rx_over, tx_under;
    logic [DW-1:0] ev, clr_v, set_v;

    always_comb begin
        rx_acc   = rx_strobe && rx_en;
        tx_acc   = tx_take && tx_en;
        rx_over  = rx_acc && rx_rdy && !rhr_rd;
        tx_under = tx_acc && tx_empty;
        ev       = '0;
        if (rx_over) begin
            ev[B_RXOVR]              = 1'b1;
            ev[B_RXCH + int'(rx_chan)] = 1'b1;
        end
        if (tx_under) begin
            ev[B_TXUR]               = 1'b1;
            ev[B_TXCH + int'(tx_chan)] = 1'b1;
        end
        clr_v = sclr ? wdata : '0;
        set_v = sset ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || swrst) begin
            stk      <= '0;
            rx_rdy   <= 1'b0;
            tx_empty <= 1'b1;
            rx_hold  <= '0;
            tx_hold  <= '0;
        end else begin
            stk <= ((stk & ~clr_v) | set_v | ev) & STK;
            if (rx_acc) begin
                rx_hold <= rx_sample;
                rx_rdy  <= 1'b1;
            end else if (rhr_rd) begin
                rx_rdy  <= 1'b0;
            end
            if (thr_wr) begin
                tx_hold  <= wdata[SW-1:0];
                tx_empty <= 1'b0;
            end else if (tx_acc) begin
                tx_empty <= 1'b1;
            end
        end
    end

    always_comb begin
        status          = stk;
        status[B_RXEN]  = rx_en;
        status[B_RXRDY] = rx_rdy;
        status[B_TXEN]  = tx_en;
        status[B_TXRDY] = tx_empty;
    end

    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rhr_rd && !rx_acc) |=> !rx_rdy); // R5

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stk[B_RXOVR] && !swrst && !(sclr && wdata[B_RXOVR])) |=> stk[B_RXOVR]); // R7

    AST_UR_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (tx_under && !swrst) |=> (stk[B_TXUR] && (stk[B_TXCH +: NCH] != '0))); // R6

    AST_SET_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
        (sset && !rx_acc && !rhr_rd && !swrst) |=> $stable(rx_rdy)); // R8

    AST_NO_OVR_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !sset && !swrst && !stk[B_RXOVR]) |=> !stk[B_RXOVR]); // R5

endmodule

// File: rtl/aud_csr_irq.sv
module aud_csr_irq
    import aud_csr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          swrst,
    input  logic          ien,
    input  logic          idis,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] status,
    output logic [DW-1:0] mask,
    output logic          irq
);

    logic [DW-1:0] en_v, dis_v;

    always_comb begin
        en_v  = ien  ? (wdata & IRQ_BITS) : '0;
        dis_v = idis ? (wdata & IRQ_BITS) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || swrst)
            mask <= '0;
        else
            mask <= (mask | en_v) & ~dis_v;
    end

    assign irq = |(status & mask);

    AST_IEN_SETS: assert property (@(posedge clk) disable iff (rst)
        ien |=> ((mask & $past(wdata & IRQ_BITS)) == $past(wdata & IRQ_BITS))); // R9

    AST_IDIS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        idis |=> ((mask & $past(wdata)) == '0)); // R9

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask != '0)); // R10

endmodule

// File: rtl/aud_csr_top.sv
module aud_csr_top
    import aud_csr_pkg::*;
#(
    parameter int unsigned NCH      = 8,
    parameter int unsigned SAMPLE_W = 32,
    parameter logic [31:0] VERSION  = 32'h0001_0203,
    localparam int unsigned CH_W    = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic                rx_strobe,
    input  logic [CH_W-1:0]     rx_chan,
    input  logic [SAMPLE_W-1:0] rx_sample,
    input  logic                tx_take,
    input  logic [CH_W-1:0]     tx_chan,
    output logic [SAMPLE_W-1:0] tx_sample,
    output logic                rx_enable,
    output logic                tx_enable,
    output logic                clk_enable,
    output logic [DW-1:0]       mode_cfg,
    output logic                irq
);

    logic [3:0]          widx;
    logic                unused_addr_lsb;
    csr_strb_t           strb;
    logic                swrst;
    logic [NFUNC-1:0]    en;
    logic [DW-1:0]       status, mask;
    logic [SAMPLE_W-1:0] rx_hold;

    assign widx            = bus_addr[5:2];
    assign unused_addr_lsb = ^bus_addr[1:0];
    assign strb            = csr_decode(bus_sel, bus_wr, widx);
    assign swrst           = strb.cmd && bus_wdata[B_SWRST];

    aud_csr_cmd i_cmd (
        .clk      (clk),
        .rst      (rst),
        .swrst    (swrst),
        .cmd_we   (strb.cmd),
        .cmd_bits (bus_wdata[2*NFUNC-1:0]),
        .en       (en)
    );

    assign rx_enable  = en[FN_RX];
    assign clk_enable = en[FN_CLK];
    assign tx_enable  = en[FN_TX];

    aud_csr_status #(.NCH(NCH), .SW(SAMPLE_W)) i_status (
        .clk       (clk),
        .rst       (rst),
        .swrst     (swrst),
        .rx_en     (rx_enable),
        .tx_en     (tx_enable),
        .sclr      (strb.sclr),
        .sset      (strb.sset),
        .thr_wr    (strb.thr_wr),
        .rhr_rd    (strb.rhr_rd),
        .wdata     (bus_wdata),
        .rx_strobe (rx_strobe),
        .rx_chan   (rx_chan),
        .rx_sample (rx_sample),
        .tx_take   (tx_take),
        .tx_chan   (tx_chan),
        .status    (status),
        .rx_hold   (rx_hold),
        .tx_hold   (tx_sample)
    );

    aud_csr_irq i_irq (
        .clk    (clk),
        .rst    (rst),
        .swrst  (swrst),
        .ien    (strb.ien),
        .idis   (strb.idis),
        .wdata  (bus_wdata),
        .status (status),
        .mask   (mask),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst || swrst)
            mode_cfg <= '0;
        else if (strb.mode)
            mode_cfg <= bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (widx)
                W_MODE:  bus_rdata = mode_cfg;
                W_STAT:  bus_rdata = status;
                W_IMSK:  bus_rdata = mask;
                W_RHR:   bus_rdata = DW'(rx_hold);
                W_VER:   bus_rdata = VERSION;
                default: bus_rdata = '0;
            endcase
        end
    end

    AST_SWRST_ZEROES: assert property (@(posedge clk) disable iff (rst)
        swrst |=> (mode_cfg == '0 && !rx_enable && !tx_enable && !clk_enable && !irq)); // R1

    AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && (widx == W_THR || widx == W_CMD)) |-> (bus_rdata == '0)); // R11

    AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (strb.mode) |=> (mode_cfg == $past(bus_wdata))); // R3

endmodule

// File: tb/test_aud_csr_top.sv
`timescale 1ns/1ps
module test_aud_csr_top;

    localparam logic [31:0] VER = 32'h0001_0203;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_strobe = 1'b0;
    logic [2:0]  rx_chan = '0;
    logic [31:0] rx_sample = '0;
    logic        tx_take = 1'b0;
    logic [2:0]  tx_chan = '0;
    logic [31:0] tx_sample;
    logic        rx_enable, tx_enable, clk_enable, irq;
    logic [31:0] mode_cfg;

    always #2.5 clk = ~clk;

    aud_csr_top i_aud_csr_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_strobe(rx_strobe), .rx_chan(rx_chan), .rx_sample(rx_sample),
        .tx_take(tx_take), .tx_chan(tx_chan), .tx_sample(tx_sample),
        .rx_enable(rx_enable), .tx_enable(tx_enable), .clk_enable(clk_enable),
        .mode_cfg(mode_cfg), .irq(irq)
    );

    int    nchk = 0;
    int    nerr = 0;
    bit    done = 0;
    string cur_tag = "R4";

    // behavioural model state
    bit          m_rxen, m_txen, m_cken, m_rxrdy, m_txemp, m_rxovr, m_txur;
    logic [7:0]  m_rxch, m_txch;
    logic [31:0] m_mode, m_mask, m_rhr, m_thr;

    task automatic model_reset();
        m_rxen = 0; m_txen = 0; m_cken = 0; m_rxrdy = 0; m_txemp = 1;
        m_rxovr = 0; m_txur = 0; m_rxch = '0; m_txch = '0;
        m_mode = '0; m_mask = '0; m_rhr = '0; m_thr = '0;
    endtask

    function automatic logic [31:0] m_status();
        logic [31:0] s;
        s = '0;
        s[0] = m_rxen; s[1] = m_rxrdy; s[2] = m_rxovr;
        s[4] = m_txen; s[5] = m_txemp; s[6] = m_txur;
        s[15:8] = m_rxch; s[27:20] = m_txch;
        return s;
    endfunction

    function automatic logic [31:0] m_read();
        if (!(bus_sel && !bus_wr)) return '0;
        case (bus_addr[5:2])
            4'd1:    return m_mode;
            4'd2:    return m_status();
            4'd7:    return m_mask;
            4'd8:    return m_rhr;
            4'd10:   return VER;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit w, r, rx_on, tx_on;
        int idx;
        logic [31:0] d;
        if (rst) begin
            model_reset();
        end else begin
            w = bus_sel && bus_wr; r = bus_sel && !bus_wr;
            idx = int'(bus_addr[5:2]); d = bus_wdata;
            if (w && idx == 0 && d[7]) begin
                model_reset();
            end else begin
                rx_on = m_rxen; tx_on = m_txen;
                if (w && idx == 3) begin
                    if (d[2]) m_rxovr = 0;
                    if (d[6]) m_txur = 0;
                    m_rxch = m_rxch & ~d[15:8];
                    m_txch = m_txch & ~d[27:20];
                end
                if (w && idx == 4) begin
                    if (d[2]) m_rxovr = 1;
                    if (d[6]) m_txur = 1;
                    m_rxch = m_rxch | d[15:8];
                    m_txch = m_txch | d[27:20];
                end
                if (rx_strobe && rx_on) begin
                    if (m_rxrdy && !(r && idx == 8)) begin
                        m_rxovr = 1; m_rxch[rx_chan] = 1'b1;
                    end
                    m_rhr = rx_sample; m_rxrdy = 1;
                end else if (r && idx == 8) begin
                    m_rxrdy = 0;
                end
                if (tx_take && tx_on) begin
                    if (m_txemp) begin
                        m_txur = 1; m_txch[tx_chan] = 1'b1;
                    end
                    m_txemp = 1;
                end
                if (w && idx == 9) begin
                    m_thr = d; m_txemp = 0;
                end
                if (w && idx == 0) begin
                    if (d[1]) m_rxen = 0; else if (d[0]) m_rxen = 1;
                    if (d[3]) m_cken = 0; else if (d[2]) m_cken = 1;
                    if (d[5]) m_txen = 0; else if (d[4]) m_txen = 1;
                end
                if (w && idx == 1) m_mode = d;
                if (w && idx == 5) m_mask = m_mask | (d & 32'h66);
                if (w && idx == 6) m_mask = m_mask & ~d;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare every output each cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2", "rx_enable", 32'(rx_enable), 32'(m_rxen));
            chk("R2", "tx_enable", 32'(tx_enable), 32'(m_txen));
            chk("R2", "clk_enable", 32'(clk_enable), 32'(m_cken));
            chk("R3", "mode_cfg", mode_cfg, m_mode);
            chk("R6", "tx_sample", tx_sample, m_thr);
            chk("R10", "irq", 32'(irq), 32'(|(m_status() & m_mask)));
            chk(cur_tag, "bus_rdata", bus_rdata, m_read());
        end
    end

    task automatic cyc(input logic s, input logic w, input logic [3:0] idx,
                       input logic [31:0] d, input logic rs, input logic [2:0] rc,
                       input logic [31:0] rd, input logic tt, input logic [2:0] tc);
        @(posedge clk); #1;
        bus_sel = s; bus_wr = w; bus_addr = {idx, 2'b00}; bus_wdata = d;
        rx_strobe = rs; rx_chan = rc; rx_sample = rd; tx_take = tt; tx_chan = tc;
    endtask

    task automatic idle();                                   cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic wr_reg(input logic [3:0] i, input logic [31:0] d); cyc(1, 1, i, d, 0, 0, 0, 0, 0); endtask
    task automatic strobe(input logic [2:0] c, input logic [31:0] d); cyc(0, 0, 0, 0, 1, c, d, 0, 0); endtask
    task automatic take(input logic [2:0] c);                 cyc(0, 0, 0, 0, 0, 0, 0, 1, c); endtask

    task automatic hand(input logic [3:0] i, input logic [31:0] exp, input string tag);
        cyc(1, 0, i, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(tag, "directed read", bus_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R1 watchdog expired act=0 exp=1");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;

        cur_tag = "R1";
        hand(W_STAT_I(), 32'h20, "R1");
        cur_tag = "R11";
        hand(4'd10, VER, "R11");
        hand(4'd0, 32'h0, "R11");

        cur_tag = "R3";
        wr_reg(4'd1, 32'hA5A5_1234);
        hand(4'd1, 32'hA5A5_1234, "R3");

        cur_tag = "R2";
        wr_reg(4'd0, 32'h15);
        hand(4'd2, 32'h31, "R2");
        wr_reg(4'd0, 32'h0C);                 // clock on+off together -> off
        idle();
        @(negedge clk) chk("R2", "clk both bits", 32'(clk_enable), 32'h0);
        wr_reg(4'd0, 32'h03);                 // receiver on+off -> off
        wr_reg(4'd0, 32'h01);

        cur_tag = "R5";
        strobe(3, 32'h11);
        hand(4'd8, 32'h11, "R5");
        strobe(5, 32'h22);
        strobe(5, 32'h33);
        hand(4'd2, 32'h2037, "R5");
        cyc(1, 0, 4'd8, 0, 1, 6, 32'h44, 0, 0); // read with strobe: no overrun
        hand(4'd2, 32'h2037, "R5");

        cur_tag = "R7";
        wr_reg(4'd5, 32'h04);
        cyc(1, 1, 4'd3, 32'h2004, 1, 1, 32'h55, 0, 0); // clear vs new event
        hand(4'd2, 32'h237, "R7");
        wr_reg(4'd3, 32'h0FF0_FF44);
        hand(4'd2, 32'h33, "R7");

        cur_tag = "R6";
        take(2);
        hand(4'd2, 32'h40_0073, "R6");
        wr_reg(4'd9, 32'hBEEF);
        hand(4'd2, 32'h40_0053, "R6");
        take(4);
        hand(4'd2, 32'h40_0073, "R6");

        cur_tag = "R8";
        wr_reg(4'd4, 32'hFFFF_FFFF);
        hand(4'd2, 32'h0FF0_FF77, "R8");

        cur_tag = "R9";
        wr_reg(4'd5, 32'hFFFF_FFFF);
        hand(4'd7, 32'h66, "R9");
        wr_reg(4'd6, 32'h22);
        hand(4'd7, 32'h44, "R9");
        wr_reg(4'd7, 32'h0);
        hand(4'd7, 32'h44, "R9");

        cur_tag = "R11";
        hand(4'd11, 32'h0, "R11");
        wr_reg(4'd10, 32'h0);
        hand(4'd10, VER, "R11");
        hand(4'd9, 32'h0, "R11");

        cur_tag = "R5";
        wr_reg(4'd0, 32'h22);
        wr_reg(4'd3, 32'hFFFF_FFFF);
        cyc(0, 0, 0, 0, 1, 7, 32'h99, 1, 7);   // both ignored while off
        hand(4'd2, 32'h22, "R5");
        hand(4'd8, 32'h55, "R6");

        cur_tag = "R1";
        wr_reg(4'd0, 32'h95);
        hand(4'd2, 32'h20, "R1");
        hand(4'd7, 32'h0, "R1");
        hand(4'd1, 32'h0, "R1");

        cur_tag = "R4";
        for (int n = 0; n < 600; n++) begin
            logic [31:0] rv, dv;
            logic [3:0]  ix;
            rv = $urandom;
            dv = $urandom;
            ix = 4'(rv[3:0] % 12);
            if (ix == 4'd0 && rv[11:8] != 4'd0) dv[7] = 1'b0;
            cyc(rv[4], rv[5], ix, dv, rv[6], rv[14:12], $urandom, rv[7], rv[18:16]);
        end
        idle();
        @(negedge clk);
        finish_run();
    end

    function automatic logic [3:0] W_STAT_I();
        return 4'd2;
    endfunction

endmodule